// File: doc/BRIEF.md
# Clock Failure Detector with Switch-Back

This block supervises an external oscillator clock from a reference clock that is known to be running. The reference clock is divided by a power of two to make a slow "safe" time base, and the monitored clock is brought into the reference domain through a two-flop synchronizer. The block counts time in observation windows of four safe-clock periods. If one of these windows contains no rising edge of the monitored clock, the block declares a failure. It then reports that the clock source has moved to the safe clock and sets a sticky failure status bit.

While it runs on the safe clock, the block keeps counting windows that do contain monitored edges. After eight such windows in a row, the external clock counts as recovered. If switch-back is allowed at that point, the source indicator returns to the external clock and a one-cycle completion pulse is given. Surrounding logic uses this pulse to clear its switch-back enable bit. The glitch-free clock multiplexer itself lies outside this block and is driven by the source indicator.

Whenever the detector is enabled, the block raises the failure status once as a start-up artefact. Software must discard this first indication.

Top module: `cfd_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `src_safe`, `fail_sts` and `swb_done` are all 0.
- R2: The prescaler select N is captured while the detector is disabled. A window lasts 4 x 2^N reference cycles, counted from the edge at which the registered enable rises. Changes to `presc_sel` while the detector is enabled have no effect.
- R3: On the second reference edge after `det_en` is first sampled high, `fail_sts` becomes 1 even when the monitored clock is running. `src_safe` is not changed by this.
- R4: A window that contains no rising edge of `mon_clk`, after two-flop synchronization, sets `src_safe` to 1 (safe clock) and sets `fail_sts` on the edge that closes the window.
- R5: `fail_sts` stays 1 until a cycle in which `fail_clr` is sampled high. If a set and a clear fall in the same cycle, the set wins.
- R6: Recovery needs 8 consecutive windows that each contain a monitored rising edge. A window without an edge restarts the count from zero.
- R7: If `swb_en` is high at the window end that completes recovery, or at any later window end that contains an edge, `src_safe` returns to 0 on that edge.
- R8: If `swb_en` is low, `src_safe` stays 1 after a failure for as long as the detector stays enabled.
- R9: On the second edge after `det_en` is sampled low, `src_safe` is 0. Switch-back enable has no effect while the detector is disabled, and no `swb_done` pulse is produced.
- R10: `swb_done` is high for exactly one cycle, and only in the cycle in which `src_safe` has just fallen from 1 because of a switch-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all registers run on it |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored external clock, sampled asynchronously |
| det_en | input | 1 | Detector enable |
| presc_sel | input | 4 | Safe-clock division exponent N (divide by 2^N) |
| swb_en | input | 1 | Switch-back to the external clock is allowed |
| fail_clr | input | 1 | Write-one-to-clear strobe for the failure status |
| src_safe | output | 1 | 1 = safe clock selected, 0 = external clock selected |
| fail_sts | output | 1 | Sticky failure status |
| swb_done | output | 1 | One-cycle pulse when switch-back completes |

## Verification
The bench goes after window alignment. A design that counted windows from the wrong edge, or that did not freeze the prescaler at enable, would declare failure several cycles early or late, and the cycle-by-cycle scoreboard would catch the drift. Recovery is broken partway by a burst with no edges. A design that did not clear its good-window count at that point would switch back too soon. The bench holds the clear strobe across a real failure to show that a set beats a clear, and it disables the detector while running on the safe clock with switch-back allowed. A design that produced a completion pulse at that moment, or that stayed on the safe clock, is reported.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    localparam int CFD_SEL_W       = 4;
    localparam int CFD_WIN_TICKS   = 4;
    localparam int CFD_GOOD_WINS   = 8;
    localparam int CFD_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CFD_OFF   = 2'd0,
        CFD_WATCH = 2'd1,
        CFD_SAFE  = 2'd2
    } cfd_state_e;

    typedef struct packed {
        logic wend;   // last safe tick of a window
        logic good;   // window held at least one monitored rise
    } win_evt_t;

    // terminal count for a divide by 2^sel
    function automatic logic [31:0] div_mask(input logic [31:0] sel);
        return (32'd1 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/cfd_presc.sv
module cfd_presc
    import cfd_pkg::*;
#(
    parameter int SEL_W = CFD_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_q,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] lim_sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'(div_mask(32'(lim_sel)));
    assign tick = en_q && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_sel <= '0;
            cnt     <= '0;
        end else if (!en_q) begin
            lim_sel <= sel;
            cnt     <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // divider choice is frozen while the detector runs
    p_sel_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q)) |-> $stable(lim_sel));

endmodule

// File: rtl/cfd_sync_rise.sv
module cfd_sync_rise
    import cfd_pkg::*;
#(
    parameter int STAGES = CFD_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/cfd_window.sv
module cfd_window
    import cfd_pkg::*;
#(
    parameter int WIN_TICKS = CFD_WIN_TICKS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_q,
    input  logic     tick,
    input  logic     rise,
    output win_evt_t evt
);
    localparam int WC_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;

    logic last_tick;
    logic seen;

    generate
        if (WIN_TICKS > 1) begin : g_cnt
            logic [WC_W-1:0] wcnt;
            always_ff @(posedge clk) begin
                if (rst || !en_q) begin
                    wcnt <= '0;
                end else if (tick) begin
                    if (wcnt == WC_W'(WIN_TICKS - 1)) wcnt <= '0;
                    else                             wcnt <= wcnt + 1'b1;
                end
            end
            assign last_tick = tick && (wcnt == WC_W'(WIN_TICKS - 1));
        end else begin : g_one
            assign last_tick = tick;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en_q)   seen <= 1'b0;
        else if (last_tick) seen <= 1'b0;
        else if (rise)      seen <= 1'b1;
    end

    always_comb begin
        evt.wend = last_tick;
        evt.good = seen | rise;
    end

endmodule

// File: rtl/cfd_fsm.sv
module cfd_fsm
    import cfd_pkg::*;
#(
    parameter int GOOD_WINS = CFD_GOOD_WINS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_q,
    input  win_evt_t evt,
    input  logic     swb_en,
    output logic     src_safe,
    output logic     fail_set,
    output logic     swb_done
);
    localparam int GW_W = $clog2(GOOD_WINS + 1);
    localparam logic [GW_W-1:0] GOOD_LAST = GW_W'(GOOD_WINS);

    cfd_state_e      state, state_n;
    logic [GW_W-1:0] gcnt, gcnt_n, gcnt_inc;
    logic            done_n;
    logic            swb_eff;

    // switch-back permission only counts while the detector is on
    assign swb_eff  = swb_en & en_q;
    assign gcnt_inc = (gcnt == GOOD_LAST) ? gcnt : gcnt + 1'b1;

    always_comb begin
        state_n  = state;
        gcnt_n   = gcnt;
        fail_set = 1'b0;
        done_n   = 1'b0;
        if (!en_q) begin
            state_n = CFD_OFF;
            gcnt_n  = '0;
        end else begin
            unique case (state)
                CFD_OFF: begin
                    state_n  = CFD_WATCH;
                    fail_set = 1'b1;        // start-up artefact
                end
                CFD_WATCH: begin
                    if (evt.wend && !evt.good) begin
                        state_n  = CFD_SAFE;
                        gcnt_n   = '0;
                        fail_set = 1'b1;
                    end
                end
                CFD_SAFE: begin
                    if (evt.wend) begin
                        if (!evt.good) begin
                            gcnt_n = '0;
                        end else if (gcnt_inc == GOOD_LAST && swb_eff) begin
                            state_n = CFD_WATCH;
                            gcnt_n  = '0;
                            done_n  = 1'b1;
                        end else begin
                            gcnt_n = gcnt_inc;
                        end
                    end
                end
                default: state_n = CFD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CFD_OFF;
            gcnt     <= '0;
            swb_done <= 1'b0;
        end else begin
            state    <= state_n;
            gcnt     <= gcnt_n;
            swb_done <= done_n;
        end
    end

    assign src_safe = (state == CFD_SAFE);

    p_safe_needs_empty_window_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(src_safe) |-> $past(evt.wend && !evt.good));

    p_good_count_capped_r6: assert property (@(posedge clk) disable iff (rst)
        gcnt <= GOOD_LAST);

    p_done_with_return_r10: assert property (@(posedge clk) disable iff (rst)
        swb_done |-> (!src_safe && $past(src_safe)));

    p_off_when_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (!src_safe && !swb_done));

endmodule

// File: rtl/cfd_monitor.sv
module cfd_monitor
    import cfd_pkg::*;
#(
    parameter int SEL_W       = CFD_SEL_W,
    parameter int WIN_TICKS   = CFD_WIN_TICKS,
    parameter int GOOD_WINS   = CFD_GOOD_WINS,
    parameter int SYNC_STAGES = CFD_SYNC_STAGES
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             mon_clk,
    input  logic             det_en,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             swb_en,
    input  logic             fail_clr,
    output logic             src_safe,
    output logic             fail_sts,
    output logic             swb_done
);
    logic     en_q;
    logic     tick;
    logic     rise;
    logic     fail_set;
    win_evt_t evt;

    always_ff @(posedge clk_ref) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= det_en;
    end

    cfd_presc #(.SEL_W(SEL_W)) u_presc (
        .clk  (clk_ref),
        .rst  (rst),
        .en_q (en_q),
        .sel  (presc_sel),
        .tick (tick)
    );

    cfd_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk_ref),
        .rst  (rst),
        .din  (mon_clk),
        .rise (rise)
    );

    cfd_window #(.WIN_TICKS(WIN_TICKS)) u_window (
        .clk  (clk_ref),
        .rst  (rst),
        .en_q (en_q),
        .tick (tick),
        .rise (rise),
        .evt  (evt)
    );

    cfd_fsm #(.GOOD_WINS(GOOD_WINS)) u_fsm (
        .clk      (clk_ref),
        .rst      (rst),
        .en_q     (en_q),
        .evt      (evt),
        .swb_en   (swb_en),
        .src_safe (src_safe),
        .fail_set (fail_set),
        .swb_done (swb_done)
    );

    // sticky status: set beats clear
    always_ff @(posedge clk_ref) begin
        if (rst)           fail_sts <= 1'b0;
        else if (fail_set) fail_sts <= 1'b1;
        else if (fail_clr) fail_sts <= 1'b0;
    end

    p_status_sticky_r5: assert property (@(posedge clk_ref) disable iff (rst)
        $fell(fail_sts) |-> $past(fail_clr));

    p_startup_flag_r3: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(en_q) |=> fail_sts);

endmodule

// File: tb/cfd_monitor_bench.sv
module cfd_monitor_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic       mon_clk = 1'b0;
    logic       det_en = 1'b0;
    logic [3:0] presc_sel = 4'd0;
    logic       swb_en = 1'b0;
    logic       fail_clr = 1'b0;
    logic       src_safe, fail_sts, swb_done;

    cfd_monitor u_cfd_monitor (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .mon_clk   (mon_clk),
        .det_en    (det_en),
        .presc_sel (presc_sel),
        .swb_en    (swb_en),
        .fail_clr  (fail_clr),
        .src_safe  (src_safe),
        .fail_sts  (fail_sts),
        .swb_done  (swb_done)
    );

    always #4 clk_ref = ~clk_ref;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int done_cnt = 0;
    bit mon_run  = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int c;
        bit src;
        bit sts;
        bit done;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial forever begin
        @(posedge clk_ref);
        cyc = cyc + 1;
    end

    // monitored clock: toggles every 3 reference cycles while running
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk_ref);
            #1;
            if (mon_run) begin
                ph++;
                if (ph == 3) begin
                    ph = 0;
                    mon_clk = ~mon_clk;
                end
            end
        end
    end

    // ---------------- scoreboard: expectation model and monitor ----------
    bit s_rst = 1'b1, s_en = 1'b0, s_mon = 1'b0, s_swb = 1'b0, s_clr = 1'b0;
    int s_presc = 0;
    bit m_en = 1'b0, m_prev_mon = 1'b0, m_src = 1'b0, m_sts = 1'b0, m_done = 1'b0;
    int m_state = 0, m_good = 0, m_t0 = -100000, m_p = 1;
    int t_last = -100000, t_prev = -100000;

    function automatic bit in_win(input int t, input int c, input int w);
        return (t >= c - w - 1) && (t <= c - 2);
    endfunction

    initial forever begin
        @(negedge clk_ref);
        begin
            int c, w;
            bit en_prev, wend, good, set;
            exp_t e, got;
            c = cyc;
            set = 1'b0;
            if (s_rst) begin
                m_en = 0; m_prev_mon = 0; m_src = 0; m_sts = 0; m_done = 0;
                m_state = 0; m_good = 0; m_t0 = -100000;
                t_last = -100000; t_prev = -100000;
            end else begin
                en_prev = m_en;
                w = 4 * m_p;
                wend = en_prev && (c > m_t0) && (((c - m_t0) % w) == 0);
                good = in_win(t_last, c, w) || in_win(t_prev, c, w);
                if (s_mon && !m_prev_mon) begin
                    t_prev = t_last;
                    t_last = c;
                end
                m_prev_mon = s_mon;
                m_done = 0;
                if (!en_prev) begin
                    m_state = 0; m_src = 0; m_good = 0;
                end else if (m_state == 0) begin
                    m_state = 1; set = 1;
                end else if (wend) begin
                    if (m_state == 1) begin
                        if (!good) begin
                            m_state = 2; m_src = 1; m_good = 0; set = 1;
                        end
                    end else begin
                        if (!good) m_good = 0;
                        else begin
                            if (m_good < 8) m_good++;
                            if (m_good == 8 && s_swb) begin
                                m_state = 1; m_src = 0; m_good = 0; m_done = 1;
                            end
                        end
                    end
                end
                if (set)        m_sts = 1;
                else if (s_clr) m_sts = 0;
                m_en = s_en;
                if (m_en && !en_prev) begin
                    m_t0 = c;
                    m_p  = 1 << s_presc;
                end
            end
            e.c = c; e.src = m_src; e.sts = m_sts; e.done = m_done;
            sb_q.push_back(e);
            // monitor side
            got = sb_q.pop_front();
            if (swb_done === 1'b1) done_cnt++;
            if (!s_rst && cyc > 1) begin
                chk(src_safe === got.src, "R4", "src_safe", int'(src_safe), int'(got.src));
                chk(fail_sts === got.sts, "R5", "fail_sts", int'(fail_sts), int'(got.sts));
                chk(swb_done === got.done, "R10", "swb_done", int'(swb_done), int'(got.done));
            end
            // capture inputs for the next edge
            s_rst = rst; s_en = det_en; s_mon = mon_clk; s_swb = swb_en;
            s_clr = fail_clr; s_presc = int'(presc_sel);
        end
    end

    // ---------------- driver ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    initial begin
        int dc;
        step(5);
        #2;
        chk(src_safe === 1'b0 && fail_sts === 1'b0 && swb_done === 1'b0,
            "R1", "outputs in reset", int'({src_safe, fail_sts, swb_done}), 0);
        rst = 1'b0;
        step(1);
        #2;
        chk(src_safe === 1'b0 && fail_sts === 1'b0, "R1", "outputs after reset",
            int'({src_safe, fail_sts}), 0);

        // enable with N=2 (window 16 cycles), clock running
        step(1);
        presc_sel = 4'd2; mon_run = 1'b1; det_en = 1'b1;
        step(2);
        #2;
        chk(fail_sts === 1'b1, "R3", "start-up status", int'(fail_sts), 1);
        chk(src_safe === 1'b0, "R3", "source after start-up", int'(src_safe), 0);
        presc_sel = 4'd0;               // must be ignored
        fail_clr = 1'b1;
        step(1);
        fail_clr = 1'b0;
        step(160);
        chk(src_safe === 1'b0 && fail_sts === 1'b0, "R2",
            "no false failure after select change", int'({src_safe, fail_sts}), 0);

        // failure 1
        mon_run = 1'b0;
        step(48);
        chk(src_safe === 1'b1, "R4", "switched to safe clock", int'(src_safe), 1);
        chk(fail_sts === 1'b1, "R4", "failure status", int'(fail_sts), 1);
        step(10);
        chk(fail_sts === 1'b1, "R5", "status sticky", int'(fail_sts), 1);
        fail_clr = 1'b1;
        step(1);
        fail_clr = 1'b0;
        step(1);
        chk(fail_sts === 1'b0, "R5", "status cleared", int'(fail_sts), 0);

        // recovery without switch-back
        mon_run = 1'b1;
        step(192);
        chk(src_safe === 1'b1, "R8", "stays on safe clock", int'(src_safe), 1);
        chk(done_cnt == 0, "R8", "no completion pulse", done_cnt, 0);
        swb_en = 1'b1;
        step(32);
        chk(src_safe === 1'b0, "R7", "switched back", int'(src_safe), 0);
        chk(done_cnt == 1, "R10", "single completion pulse", done_cnt, 1);
        swb_en = 1'b0;

        // failure 2 with the clear strobe held across it
        fail_clr = 1'b1;
        mon_run = 1'b0;
        step(60);
        chk(src_safe === 1'b1, "R4", "second failure", int'(src_safe), 1);
        chk(fail_sts === 1'b0, "R5", "clear held through set", int'(fail_sts), 0);
        fail_clr = 1'b0;

        // interrupted recovery
        swb_en = 1'b1;
        mon_run = 1'b1;
        step(80);
        chk(src_safe === 1'b1, "R6", "too few good windows", int'(src_safe), 1);
        mon_run = 1'b0;
        step(40);
        mon_run = 1'b1;
        step(96);
        chk(src_safe === 1'b1, "R6", "count restarted after empty window", int'(src_safe), 1);
        step(64);
        chk(src_safe === 1'b0, "R6", "recovered after eight windows", int'(src_safe), 0);
        chk(done_cnt == 2, "R7", "second completion pulse", done_cnt, 2);

        // failure 3, then disable with switch-back allowed
        mon_run = 1'b0;
        step(48);
        chk(src_safe === 1'b1, "R4", "third failure", int'(src_safe), 1);
        dc = done_cnt;
        mon_run = 1'b1;
        det_en = 1'b0;
        step(2);
        #2;
        chk(src_safe === 1'b0, "R9", "external source when disabled", int'(src_safe), 0);
        step(200);
        chk(done_cnt == dc, "R9", "no pulse while disabled", done_cnt, dc);

        // re-enable with N=1 (window 8 cycles), clock stopped
        mon_run = 1'b0;
        step(20);
        presc_sel = 4'd1;
        det_en = 1'b1;
        step(6);
        #2;
        chk(src_safe === 1'b0, "R2", "no failure before first window", int'(src_safe), 0);
        step(5);
        #2;
        chk(src_safe === 1'b1, "R2", "failure after 8-cycle window", int'(src_safe), 1);
        step(10);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk_ref);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

endmodule